// File: doc/BRIEF.md
# Calibration Interval Timer

This block counts out a programmable interval and flags when it has run out. Software or an event fabric then uses that flag to recalibrate a low-frequency RC oscillator. The interval is given in quarter-second units. A parameter sets how many system clock cycles make one unit, so a simulation can use a short unit and the countdown has no drift against the system clock. Once started, the timer runs a single countdown and then stops; it does not reload.

Pulses on the start and stop task inputs control the timer. Each task is acknowledged through a sticky event flag. A third flag marks the expiry. Each flag has its own interrupt enable bit, and a single level interrupt is raised while any enabled flag is set. A flag stays set until its clear bit is pulsed.

Flag and enable bit positions: bit 0 is started, bit 1 is stopped, bit 2 is timeout.

Top module: `cal_interval_timer`

## Requirements
- R1: While reset is held and after reset is released, `running_o` is 0, all three event flags are 0 and `irq_o` is 0.
- R2: A start task accepted while the timer is stopped sets `running_o` and loads the interval N. For N > 0, the timeout flag (bit 2) rises exactly N*TICKS_PER_UNIT clock edges after the edge that accepted the start.
- R3: A start task accepted while the timer is running leaves the countdown unchanged. The timeout still arrives at the time set by the first start.
- R4: The started flag (bit 0) is set on the same edge that accepts a start task, whether the timer was stopped or running.
- R5: A stop task clears `running_o`, cancels any pending timeout and sets the stopped flag (bit 1) on that same edge. It does so even when the timer is already stopped.
- R6: On expiry `running_o` falls and the timeout flag is set on the same edge. The timer then stays stopped until the next start.
- R7: The interval input is sampled only when a start is accepted from the stopped state. Changing it during a countdown has no effect on that countdown.
- R8: An interval of zero expires on the edge after the edge that accepted the start.
- R9: When start and stop tasks arrive in the same cycle, the stop wins. The timer ends stopped, the stopped flag is set and the started flag is not.
- R10: Event flags are sticky and are cleared only by the matching bit of `evt_clr_i`; a set and a clear in the same cycle leave the flag set. `irq_o` is the OR over the three bits of (flag AND enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_i | input | IVL_W | Timeout in quarter-second units |
| start_i | input | 1 | Start task pulse |
| stop_i | input | 1 | Stop task pulse |
| evt_clr_i | input | 3 | Per-flag clear (0 started, 1 stopped, 2 timeout) |
| irq_en_i | input | 3 | Per-flag interrupt enable, same bit order |
| running_o | output | 1 | Countdown in progress |
| evt_o | output | 3 | Sticky event flags, same bit order |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong countdown value only shows up at the end of an interval: the timeout flag and the fall of `running_o` land on the wrong edge, up to 15*TICKS_PER_UNIT cycles after the fault. For that reason, every timeout is measured against a free-running edge count and not just waited for. A wrongly handled task shows up one edge after the task: the running bit or the acknowledge flag is wrong in the very next sample. A cancelled countdown that still fires would set the timeout flag long after the stop, so the bench watches the flag for more than the full interval after every stop.

// File: rtl/cal_interval_timer.sv
module cal_interval_timer #(
  parameter int TICKS_PER_UNIT = 4,
  parameter int IVL_W          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] interval_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [2:0]       evt_clr_i,
  input  logic [2:0]       irq_en_i,
  output logic             running_o,
  output logic [2:0]       evt_o,
  output logic             irq_o
);
  localparam int SUB_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_UNIT - 1);

  logic             running_q;
  logic [IVL_W-1:0] units_q;
  logic [SUB_W-1:0] sub_q;
  logic [2:0]       evt_q;

  wire start_ok = start_i & ~stop_i;
  wire load     = start_ok & ~running_q;
  wire last     = (units_q == '0) | ((units_q == IVL_W'(1)) & (sub_q == '0));
  wire expire   = running_q & ~stop_i & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      units_q   <= '0;
      sub_q     <= '0;
    end else if (stop_i) begin
      running_q <= 1'b0;
    end else if (load) begin
      running_q <= 1'b1;
      units_q   <= interval_i;
      sub_q     <= SUB_LAST;
    end else if (expire) begin
      running_q <= 1'b0;
    end else if (running_q) begin
      if (sub_q == '0) begin
        sub_q   <= SUB_LAST;
        units_q <= units_q - IVL_W'(1);
      end else begin
        sub_q <= sub_q - SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~evt_clr_i) | {expire, stop_i, start_ok};
  end

  assign running_o = running_q;
  assign evt_o     = evt_q;
  assign irq_o     = |(evt_q & irq_en_i);

  a_r4_started_ack: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !stop_i |=> evt_o[0]);

  a_r5_stop_ack: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_o && evt_o[1]);

  a_r9_stop_beats_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && stop_i && !running_o |=> !running_o);

  a_r6_fall_flags_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && !stop_i |=> running_o || evt_o[2]);

  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o && !start_i |=> !running_o);

  a_r3_running_start_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && start_i && !stop_i && !last |=> running_o);

  a_r2_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> sub_q <= SUB_LAST);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_i == 3'b000 |-> !irq_o);
endmodule

// File: tb/cal_interval_timer_bench.sv
module cal_interval_timer_bench;
  localparam int PERIOD = 10;
  localparam int TICKS  = 4;
  localparam int IW     = 4;
  localparam int NVEC   = 5;
  localparam int VEC [0:NVEC-1][0:1] = '{'{1, 4}, '{3, 12}, '{5, 20}, '{0, 1}, '{15, 60}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] interval = '0;
  logic          start = 1'b0, stop = 1'b0;
  logic [2:0]    clr = '0, ien = '0;
  logic          running, irq;
  logic [2:0]    evt;
  int            cyc = 0, checks = 0, errors = 0, st = 0, d = 0;

  cal_interval_timer #(.TICKS_PER_UNIT(TICKS), .IVL_W(IW)) u_cal_interval_timer (
    .clk(clk), .rst_n(rst_n), .interval_i(interval), .start_i(start), .stop_i(stop),
    .evt_clr_i(clr), .irq_en_i(ien), .running_o(running), .evt_o(evt), .irq_o(irq));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic p, input logic [2:0] c);
    @(negedge clk);
    start = s; stop = p; clr = c;
    @(negedge clk);
    start = 1'b0; stop = 1'b0; clr = '0;
  endtask

  task automatic do_start();
    drive(1'b1, 1'b0, 3'b000);
    st = cyc;
  endtask

  task automatic wait_timeout();
    int g = 0;
    while (!evt[2] && g < 300) begin
      @(negedge clk);
      g++;
    end
    d = cyc - st;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    check("R1 running in reset", int'(running), 0);
    check("R1 flags in reset", int'(evt), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    check("R1 running after reset", int'(running), 0);
    check("R1 irq after reset", int'(irq), 0);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b0, 1'b0, 3'b111);
      interval = IW'(VEC[i][0]);
      do_start();
      check("R2 running after start", int'(running), 1);
      check("R4 started flag", int'(evt[0]), 1);
      wait_timeout();
      if (VEC[i][0] == 0) check("R8 zero interval delay", d, VEC[i][1]);
      else                check("R2 timeout delay", d, VEC[i][1]);
      check("R6 running after expiry", int'(running), 0);
    end

    idle(30);
    check("R6 no reload", int'(running), 0);
    check("R6 timeout flag sticky", int'(evt[2]), 1);

    drive(1'b0, 1'b0, 3'b111);
    interval = 4'd4;
    do_start();
    interval = 4'd15;
    idle(5);
    drive(1'b0, 1'b0, 3'b001);
    check("R10 clear started", int'(evt[0]), 0);
    drive(1'b1, 1'b0, 3'b000);
    check("R4 started flag while running", int'(evt[0]), 1);
    check("R3 still running", int'(running), 1);
    wait_timeout();
    check("R3 timeout not restarted", d, 16);
    check("R7 interval change ignored", d, 16);

    drive(1'b0, 1'b0, 3'b111);
    interval = 4'd3;
    do_start();
    idle(4);
    drive(1'b0, 1'b1, 3'b000);
    check("R5 stop clears running", int'(running), 0);
    check("R5 stopped flag", int'(evt[1]), 1);
    idle(40);
    check("R5 timeout cancelled", int'(evt[2]), 0);

    drive(1'b0, 1'b0, 3'b111);
    drive(1'b0, 1'b1, 3'b000);
    check("R5 stop while idle flag", int'(evt[1]), 1);
    check("R5 stop while idle running", int'(running), 0);

    drive(1'b0, 1'b0, 3'b111);
    drive(1'b1, 1'b1, 3'b000);
    check("R9 running", int'(running), 0);
    check("R9 started flag", int'(evt[0]), 0);
    check("R9 stopped flag", int'(evt[1]), 1);

    drive(1'b0, 1'b0, 3'b111);
    drive(1'b1, 1'b0, 3'b001);
    check("R10 set beats clear", int'(evt[0]), 1);
    ien = 3'b000;
    idle(1);
    check("R10 irq masked", int'(irq), 0);
    ien = 3'b010;
    idle(1);
    check("R10 irq other flag only", int'(irq), 0);
    ien = 3'b001;
    idle(1);
    check("R10 irq enabled", int'(irq), 1);
    drive(1'b0, 1'b0, 3'b001);
    check("R10 irq after clear", int'(irq), 0);
    drive(1'b0, 1'b1, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule